// File: doc/BRIEF.md
# DDR3 Power-Up Reset and Clock-Enable Sequencer

This block drives the memory reset and clock-enable pins of a DDR3 interface through power-up. Two registers are written through a single write port: a refresh-interval register and a configuration register. A write to the configuration register starts the sequence. The block holds the memory reset asserted for a fixed number of cycles, then releases it. It then keeps the clock enable low for a wait taken from the refresh-interval register, and finally raises the clock enable and pulses a done flag.

The wait has no timer register of its own. It is sixteen clocks per count of the refresh-interval register, sampled at the configuration write. Software therefore loads a large value first (for a 400 MHz clock, 0x3100 gives 200704 cycles, just over the 500 us the memory needs). It starts the sequence and then rewrites the register with the normal refresh interval. Once the clock enable is high, the same register paces periodic refresh request pulses. The long wait applies only when the configuration selects DDR3. Other memory types raise the clock enable together with the reset release.

Top module: `ddr3_pwrup_seq`

## Requirements
- R1: While rst_ni is low and after its release until a start, mem_rst_no, cke_o, busy_o, done_o and ref_req_o are all 0.
- R2: A write with wr_sel_i=1 (configuration) while busy_o is 0 starts a sequence: from the next cycle busy_o is 1 and mem_rst_no stays 0 for exactly RST_CYC cycles.
- R3: With configuration bit 0 set to 1 (DDR3), mem_rst_no is 1 with cke_o 0 for exactly 16 x the refresh value cycles before cke_o rises.
- R4: The wait uses the refresh value held at the configuration write; refresh writes (wr_sel_i=0) during the sequence do not change it.
- R5: With configuration bit 0 equal to 0, or a refresh value of 0, cke_o rises in the same cycle as mem_rst_no.
- R6: done_o is a one-cycle pulse in the first cycle cke_o is 1, busy_o falls in that cycle, and cke_o is never 1 while mem_rst_no is 0.
- R7: A configuration write while busy_o is 1 is ignored.
- R8: While cke_o is 1, ref_req_o pulses for one cycle every 16 x refresh value cycles; a new refresh write takes effect at the next pulse.
- R9: While cke_o is 1 and the refresh value is 0, no ref_req_o pulses occur.
- R10: A configuration write after done restarts the sequence: in the next cycle cke_o and mem_rst_no are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = refresh-interval register, 1 = configuration register |
| wr_data_i | input | REF_W | Write data; for configuration, bit 0 = 1 selects DDR3 |
| mem_rst_no | output | 1 | Memory reset, active low |
| cke_o | output | 1 | Memory clock enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when cke_o rises |
| ref_req_o | output | 1 | One-cycle periodic refresh request |

## Verification
The bench builds the block with RST_CYC=6 and the default 16-bit refresh register. Refresh values in single digits then give waits and refresh periods of a few tens of cycles. This keeps every sequence, restart, ignored write and retimed refresh interval within a few thousand cycles and still exercises the full x16 scaling. The 0x3100 power-up value itself is not run, because its wait is longer than the whole bench budget.

// File: rtl/ddr3_seq_pkg.sv
package ddr3_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_WAIT, ST_RUN} seq_state_e;
  localparam int unsigned CFG_DDR3_BIT = 0;
endpackage

// File: rtl/seq_regs.sv
module seq_regs #(
  parameter int unsigned REF_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [REF_W-1:0] wr_data_i,
  input  logic             busy_i,
  output logic [REF_W-1:0] ref_o,
  output logic             start_o,
  output logic             ddr3_o
);
  logic [REF_W-1:0] ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ref_q <= '0;
    else if (wr_en_i && !wr_sel_i) ref_q <= wr_data_i;
  end

  assign ref_o   = ref_q;
  assign start_o = wr_en_i && wr_sel_i && !busy_i;
  assign ddr3_o  = wr_data_i[ddr3_seq_pkg::CFG_DDR3_BIT];

  // R8
  ref_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i) |=> (ref_q == $past(wr_data_i)));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import ddr3_seq_pkg::*;
#(
  parameter int unsigned REF_W    = 16,
  parameter int unsigned SCALE_SH = 4,
  parameter int unsigned RST_CYC  = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ddr3_i,
  input  logic [REF_W-1:0] ref_i,
  output seq_state_e       state_o,
  output logic             done_o
);
  localparam int unsigned DLY_W = REF_W + SCALE_SH;
  localparam int unsigned RC_W  = $clog2(RST_CYC + 1);
  localparam int unsigned CNT_W = (DLY_W > RC_W) ? DLY_W : RC_W;

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DLY_W-1:0] dly_q;
  logic             ddr3_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      dly_q   <= '0;
      ddr3_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_HOLD;
        cnt_q   <= CNT_W'(RST_CYC - 1);
        dly_q   <= {ref_i, {SCALE_SH{1'b0}}};
        ddr3_q  <= ddr3_i;
      end else begin
        unique case (state_q)
          ST_HOLD: begin
            if (cnt_q == '0) begin
              if (ddr3_q && dly_q != '0) begin
                state_q <= ST_WAIT;
                cnt_q   <= CNT_W'(dly_q - 1'b1);
              end else begin
                state_q <= ST_RUN;
                done_q  <= 1'b1;
              end
            end else cnt_q <= cnt_q - 1'b1;
          end
          ST_WAIT: begin
            if (cnt_q == '0) begin
              state_q <= ST_RUN;
              done_q  <= 1'b1;
            end else cnt_q <= cnt_q - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;

  // R6
  done_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (state_q == ST_RUN && $past(state_q) != ST_RUN));
  // R5
  wait_ddr3_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> ddr3_q);
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int unsigned REF_W    = 16,
  parameter int unsigned SCALE_SH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [REF_W-1:0] ref_i,
  output logic             req_o
);
  localparam int unsigned PER_W = REF_W + SCALE_SH;

  logic [PER_W-1:0] period, cnt_q;
  logic             req_q;

  assign period = {ref_i, {SCALE_SH{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (!run_i || cnt_q == '0) begin
        // preload while idle so the first interval uses the value at entry
        cnt_q <= (period == '0) ? '0 : period - 1'b1;
        req_q <= run_i && (period != '0);
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign req_o = req_q;

  // R8
  req_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> $past(run_i));
  // R9
  zero_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && period == '0 && cnt_q == '0) |=> !req_q);
endmodule

// File: rtl/ddr3_pwrup_seq.sv
module ddr3_pwrup_seq
  import ddr3_seq_pkg::*;
#(
  parameter int unsigned REF_W    = 16,
  parameter int unsigned SCALE_SH = 4,
  parameter int unsigned RST_CYC  = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [REF_W-1:0] wr_data_i,
  output logic             mem_rst_no,
  output logic             cke_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ref_req_o
);
  logic [REF_W-1:0] ref_val;
  logic             cfg_start, cfg_ddr3;
  seq_state_e       state;

  seq_regs #(.REF_W(REF_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .busy_i (busy_o),
    .ref_o  (ref_val),
    .start_o(cfg_start),
    .ddr3_o (cfg_ddr3)
  );

  seq_fsm #(.REF_W(REF_W), .SCALE_SH(SCALE_SH), .RST_CYC(RST_CYC)) u_fsm (
    .clk_i, .rst_ni,
    .start_i(cfg_start),
    .ddr3_i (cfg_ddr3),
    .ref_i  (ref_val),
    .state_o(state),
    .done_o (done_o)
  );

  refresh_timer #(.REF_W(REF_W), .SCALE_SH(SCALE_SH)) u_ref (
    .clk_i, .rst_ni,
    .run_i(state == ST_RUN),
    .ref_i(ref_val),
    .req_o(ref_req_o)
  );

  assign mem_rst_no = (state == ST_WAIT) || (state == ST_RUN);
  assign cke_o      = (state == ST_RUN);
  assign busy_o     = (state == ST_HOLD) || (state == ST_WAIT);

  // R6
  cke_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |-> mem_rst_no);
  // R6
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cke_o && !busy_o && !$past(cke_o)));
  // R7
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !cfg_start);
endmodule

// File: tb/ddr3_pwrup_seq_tb.sv
module ddr3_pwrup_seq_tb_top;
  localparam int REF_W   = 16;
  localparam int RST_CYC = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [REF_W-1:0] wr_data = '0;
  logic mem_rst_n, cke, busy, done, ref_req;

  int tests = 0, fails = 0;

  typedef struct { int hold; int wt; } exp_t;
  exp_t sb_q[$];
  int   hold_c = 0, wait_c = 0, dones = 0;
  logic prev_done = 1'b0;

  always #4 clk = ~clk;

  ddr3_pwrup_seq #(.REF_W(REF_W), .RST_CYC(RST_CYC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .mem_rst_no(mem_rst_n), .cke_o(cke),
    .busy_o(busy), .done_o(done), .ref_req_o(ref_req)
  );

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !mem_rst_n) hold_c++;
      if (busy && mem_rst_n && !cke) wait_c++;
      if (prev_done) check("R6 done width", int'(done), 0);
      if (done) begin
        exp_t e;
        dones++;
        check("R6 cke at done", int'(cke), 1);
        check("R6 busy at done", int'(busy), 0);
        if (sb_q.size() == 0) check("R7 unexpected done", 1, 0);
        else begin
          e = sb_q.pop_front();
          check("R2 hold length", hold_c, e.hold);
          check("R3/R4/R5 wait length", wait_c, e.wt);
        end
        hold_c = 0;
        wait_c = 0;
      end
      prev_done <= done;
    end
  end

  task automatic wr(bit sel, int val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = REF_W'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic start_seq(bit ddr3, int refv);
    exp_t e;
    wr(1'b0, refv);
    e.hold = RST_CYC;
    e.wt   = (ddr3 && refv != 0) ? refv * 16 : 0;
    sb_q.push_back(e);
    wr(1'b1, int'(ddr3));
    check("R2 busy after start", int'(busy), 1);
    check("R10 reset asserted after start", int'(mem_rst_n), 0);
    check("R10 cke low after start", int'(cke), 0);
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    check("R6 done seen", int'(done), 1);
    @(negedge clk);
  endtask

  task automatic gap(output int g);
    int n = 0;
    while (!ref_req && n < 5000) begin @(negedge clk); n++; end
    g = 0;
    do begin @(negedge clk); g++; end while (!ref_req && g < 5000);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int g, cnt;
    repeat (3) @(negedge clk);
    check("R1 mem_rst in reset", int'(mem_rst_n), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 mem_rst idle", int'(mem_rst_n), 0);
    check("R1 cke idle", int'(cke), 0);
    check("R1 busy idle", int'(busy), 0);
    check("R1 done idle", int'(done), 0);
    check("R1 ref_req idle", int'(ref_req), 0);

    // R3: DDR3, refresh 5 -> 80 cycles
    start_seq(1'b1, 5);
    wait_done();
    // R8: refresh period from same register
    gap(g); check("R8 period 80", g, 80);
    wr(1'b0, 3);
    gap(g); gap(g); check("R8 period after rewrite 48", g, 48);
    @(negedge clk); check("R8 pulse width", int'(ref_req), 0);

    // R10 + R5: restart, non-DDR3 type
    start_seq(1'b0, 3);
    wait_done();

    // R4 + R7: ddr3 with 2 (32 cycles); rewrites during sequence
    start_seq(1'b1, 2);
    repeat (RST_CYC + 4) @(negedge clk);
    wr(1'b0, 20);
    wr(1'b1, 0);
    check("R7 still busy", int'(busy), 1);
    check("R7 reset still released", int'(mem_rst_n), 1);
    wait_done();
    gap(g); check("R4 refresh uses new value", g, 320);

    // R9: zero refresh value
    wr(1'b0, 0);
    repeat (400) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (ref_req) cnt++; end
    check("R9 no refresh with zero", cnt, 0);

    // R5: DDR3 with zero refresh value
    start_seq(1'b1, 0);
    wait_done();
    check("R6 done count", dones, 4);
    check("R6 scoreboard drained", sb_q.size(), 0);
    summary();
  end
endmodule